// File: doc/BRIEF.md
# Host Message-Port Target

This block is the management-controller end of a three-register byte port used by a host to exchange request and response messages. The host writes a control code, optionally a data byte, then sets the busy bit in the flags register to hand the code to the target. The target decodes the code against its current phase (ready, receiving a request, or returning a response). It then posts a status code and, where the phase calls for it, a data byte. Once those are valid it drops busy.

Request bytes leave through a write port into an external request store. A completion strobe reports the message length when the request closes cleanly. Response bytes are fetched through an address/data read port from a response store owned by the local side. That side raises a level to say a response is ready and gets a strobe back once the host has closed the read. Each phase ends with a one-byte completion code in the data register.

Top module: `msgPortTarget`

## Requirements
- R1: After reset the status register reads 0xC0, the data register reads 0x00 and the flags register reads 0x40.
- R2: Offset 0 is data, offset 1 is status on read and control on write, offset 2 is flags, and offset 3 reads 0. In flags, bit 7 is receive-ready, bit 6 is transmit-ready, bit 2 is message-available and bit 0 is busy; all other bits read 0, so flags never reads 0xFF.
- R3: A host write to flags with bit 0 set makes busy read 1 for BUSY_CYCLES cycles, after which status and data are updated and busy clears. Flags writes with bit 0 clear change nothing. Writes to any register while busy is set are ignored.
- R4: An accepted control code (0x40 get-status, 0x41 write-start, 0x42 write-next, 0x43 write-end, 0x44 read-start, 0x45 read-next, 0x46 read-end) is reported as that code with bit 7 set. Get-status in the ready phase gives status 0xC0 and data 0x00.
- R5: Write-start, write-next and write-end each store the data-register byte at successive request addresses from 0. Write-end leaves data 0x00 and pulses the completion strobe with the byte count. The data register keeps the host byte after write-start and write-next.
- R6: Bytes beyond DEPTH are not stored; write-end then gives status 0xC3, data 0x05 (buffer full) and no completion strobe. The next message starts clean.
- R7: Transmit-ready reads 1 when not busy and not in the response phase. Receive-ready reads 1 when not busy and either in the response phase or ready with a response waiting.
- R8: Read-start presents response byte 0 with status 0xC4. Each read-next presents the next byte with status 0xC5, or 0xC6 when it is the last byte.
- R9: Read-end gives status 0xC0, data 0x00, one pulse on the taken strobe, and a return to the ready phase.
- R10: Message-available is latched with the response length when the local side raises its ready level. It stays set until read-end completes, including across aborted or illegal reads.
- R11: A code not legal in the current phase gives status 0xC0, data 0x02 (illegal control) and returns to the ready phase, discarding any partial request.
- R12: Get-status during a request or response phase gives data 0x01 (aborted). Read-start with no response waiting gives data 0x03 (no response). Read-next past the last byte gives data 0x02. Each of these returns status 0xC0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 2 | Register offset |
| busRd | input | 1 | Read enable; busRdata is 0 when low |
| busWr | input | 1 | Write strobe |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for busAddr |
| reqWe | output | 1 | Request byte write enable |
| reqAddr | output | IDX_W | Request byte address |
| reqData | output | 8 | Request byte |
| reqDone | output | 1 | Request closed without error |
| reqLen | output | IDX_W | Request length, valid with reqDone |
| rspAvail | input | 1 | Local side has a response ready |
| rspLen | input | IDX_W | Response length in bytes |
| rspAddr | output | IDX_W | Response byte address |
| rspData | input | 8 | Response byte at rspAddr |
| rspTaken | output | 1 | Host finished reading the response |

## Verification
Assertions run on every cycle for the per-cycle properties: the flags value can never read as all ones, the status register always has bit 7 set, and the latched code and the data register hold still while busy. They also check that request writes never address past DEPTH and that message-available only drops on the read-end strobe. Only the bench's scenarios show the phase decoding itself. That covers status and error codes for each legal and illegal code per phase, the last-byte status on the response, and the overflow error with a clean message after it. A behavioural model in the bench also predicts the port strobes, addresses and register reads on every clock.

// File: rtl/msgTgtPkg.sv
package msgTgtPkg;

  typedef enum logic [1:0] {PH_IDLE, PH_WRITE, PH_READ} phaseT;
  typedef enum logic [1:0] {DSEL_KEEP, DSEL_ERR, DSEL_RSP} dataSelT;

  // Strobes issued by the control to the datapath in the execute cycle.
  typedef struct packed {
    logic       exec;
    logic [7:0] statusVal;
    dataSelT    dataSel;
    logic [7:0] errCode;
    logic       reqPush;
    logic       reqFinish;
    logic       wrClear;
    logic       rdAdvance;
    logic       rdClear;
    logic       rdTake;
  } strobeT;

  localparam logic [7:0] CC_GET_STATUS = 8'h40;
  localparam logic [7:0] CC_WR_START   = 8'h41;
  localparam logic [7:0] CC_WR_NEXT    = 8'h42;
  localparam logic [7:0] CC_WR_END     = 8'h43;
  localparam logic [7:0] CC_RD_START   = 8'h44;
  localparam logic [7:0] CC_RD_NEXT    = 8'h45;
  localparam logic [7:0] CC_RD_END     = 8'h46;
  localparam logic [7:0] STATUS_BIT    = 8'h80;
  localparam logic [7:0] ST_READY      = 8'hC0;

  localparam logic [7:0] ERR_NONE    = 8'h00;
  localparam logic [7:0] ERR_ABORT   = 8'h01;
  localparam logic [7:0] ERR_ILLEGAL = 8'h02;
  localparam logic [7:0] ERR_NORSP   = 8'h03;
  localparam logic [7:0] ERR_FULL    = 8'h05;

  localparam logic [1:0] OFS_DATA   = 2'd0;
  localparam logic [1:0] OFS_STATUS = 2'd1;
  localparam logic [1:0] OFS_FLAGS  = 2'd2;

endpackage

// File: rtl/msgTgtCtrl.sv
module msgTgtCtrl
  import msgTgtPkg::*;
#(
  parameter int BUSY_CYCLES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] busAddr,
  input  logic       busWr,
  input  logic [7:0] busWdata,
  input  logic       msgAvail,
  input  logic       wrFull,
  input  logic       wrOvf,
  input  logic       rdPast,
  input  logic       rdLast,
  output strobeT     strb,
  output logic       busy,
  output logic       txReady,
  output logic       rxReady,
  output logic       dataWrEn
);

  localparam int CNT_W = (BUSY_CYCLES > 2) ? $clog2(BUSY_CYCLES) : 1;

  phaseT      phase, phaseNext;
  logic [7:0] code;
  logic       exec;
  logic       ctrlWrEn;
  logic       goWr;

  assign ctrlWrEn = busWr && (busAddr == OFS_STATUS) && !busy;
  assign dataWrEn = busWr && (busAddr == OFS_DATA) && !busy;
  assign goWr     = busWr && (busAddr == OFS_FLAGS) && busWdata[0] && !busy;

  always_ff @(posedge clk) begin
    if (!rstN)         code <= CC_GET_STATUS;
    else if (ctrlWrEn) code <= busWdata;
  end

  // Busy timer: a single-cycle variant needs no counter.
  generate
    if (BUSY_CYCLES <= 1) begin : gSingle
      always_ff @(posedge clk) begin
        if (!rstN)      busy <= 1'b0;
        else if (goWr)  busy <= 1'b1;
        else if (busy)  busy <= 1'b0;
      end
      assign exec = busy;
    end else begin : gMulti
      logic [CNT_W-1:0] cnt;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          busy <= 1'b0;
          cnt  <= '0;
        end else if (goWr) begin
          busy <= 1'b1;
          cnt  <= CNT_W'(BUSY_CYCLES - 1);
        end else if (busy) begin
          if (cnt == '0) busy <= 1'b0;
          else           cnt  <= cnt - 1'b1;
        end
      end
      assign exec = busy && (cnt == '0);
    end
  endgenerate

  always_comb begin
    strb      = '0;
    phaseNext = phase;
    if (exec) begin
      strb.exec      = 1'b1;
      strb.statusVal = ST_READY;
      strb.dataSel   = DSEL_ERR;
      strb.errCode   = ERR_ILLEGAL;
      phaseNext      = PH_IDLE;
      if (phase == PH_IDLE) begin
        if (code == CC_GET_STATUS) begin
          strb.errCode = ERR_NONE;
        end else if (code == CC_WR_START) begin
          strb.statusVal = code | STATUS_BIT;
          strb.dataSel   = DSEL_KEEP;
          strb.reqPush   = 1'b1;
          phaseNext      = PH_WRITE;
        end else if (code == CC_RD_START) begin
          if (msgAvail) begin
            strb.statusVal = code | STATUS_BIT;
            strb.dataSel   = DSEL_RSP;
            strb.rdAdvance = 1'b1;
            phaseNext      = PH_READ;
          end else begin
            strb.errCode = ERR_NORSP;
          end
        end
      end else if (phase == PH_WRITE) begin
        if (code == CC_WR_NEXT) begin
          strb.statusVal = code | STATUS_BIT;
          strb.dataSel   = DSEL_KEEP;
          strb.reqPush   = 1'b1;
          phaseNext      = PH_WRITE;
        end else if (code == CC_WR_END) begin
          strb.statusVal = code | STATUS_BIT;
          strb.reqPush   = 1'b1;
          strb.errCode   = (wrOvf || wrFull) ? ERR_FULL : ERR_NONE;
          strb.reqFinish = !(wrOvf || wrFull);
          strb.wrClear   = 1'b1;
        end else begin
          if (code == CC_GET_STATUS) strb.errCode = ERR_ABORT;
          strb.wrClear = 1'b1;
        end
      end else begin
        if (code == CC_RD_NEXT && !rdPast) begin
          strb.statusVal = rdLast ? (CC_RD_END | STATUS_BIT) : (code | STATUS_BIT);
          strb.dataSel   = DSEL_RSP;
          strb.rdAdvance = 1'b1;
          phaseNext      = PH_READ;
        end else if (code == CC_RD_END) begin
          strb.errCode = ERR_NONE;
          strb.rdClear = 1'b1;
          strb.rdTake  = 1'b1;
        end else begin
          if (code == CC_GET_STATUS) strb.errCode = ERR_ABORT;
          strb.rdClear = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNext;
  end

  assign txReady = !busy && (phase != PH_READ);
  assign rxReady = !busy && ((phase == PH_READ) || ((phase == PH_IDLE) && msgAvail));

  // R10
  readNeedsMsg_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_READ) |-> msgAvail);

  // R3
  codeHeld_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(code));

endmodule

// File: rtl/msgTgtDatapath.sv
module msgTgtDatapath
  import msgTgtPkg::*;
#(
  parameter int DEPTH = 80,
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobeT           strb,
  input  logic             dataWrEn,
  input  logic [7:0]       busWdata,
  input  logic [1:0]       busAddr,
  input  logic             busRd,
  input  logic             busy,
  input  logic             txReady,
  input  logic             rxReady,
  input  logic             rspAvail,
  input  logic [IDX_W-1:0] rspLen,
  input  logic [7:0]       rspData,
  output logic [7:0]       busRdata,
  output logic             msgAvail,
  output logic             wrFull,
  output logic             wrOvf,
  output logic             rdPast,
  output logic             rdLast,
  output logic             reqWe,
  output logic [IDX_W-1:0] reqAddr,
  output logic [7:0]       reqData,
  output logic             reqDone,
  output logic [IDX_W-1:0] reqLen,
  output logic [IDX_W-1:0] rspAddr,
  output logic             rspTaken
);

  logic [7:0]       dataReg;
  logic [7:0]       statusReg;
  logic [IDX_W-1:0] wrIdx;
  logic [IDX_W-1:0] rdIdx;
  logic [IDX_W-1:0] rdLen;
  logic [7:0]       flagsVal;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataReg   <= ERR_NONE;
      statusReg <= ST_READY;
    end else if (strb.exec) begin
      statusReg <= strb.statusVal;
      case (strb.dataSel)
        DSEL_ERR: dataReg <= strb.errCode;
        DSEL_RSP: dataReg <= rspData;
        default:  dataReg <= dataReg;
      endcase
    end else if (dataWrEn) begin
      dataReg <= busWdata;
    end
  end

  assign wrFull = (wrIdx == IDX_W'(DEPTH));

  always_ff @(posedge clk) begin
    if (!rstN || strb.wrClear) begin
      wrIdx <= '0;
      wrOvf <= 1'b0;
    end else if (strb.reqPush) begin
      if (wrFull) wrOvf <= 1'b1;
      else        wrIdx <= wrIdx + IDX_W'(1);
    end
  end

  assign reqWe   = strb.reqPush && !wrFull;
  assign reqAddr = wrIdx;
  assign reqData = dataReg;
  assign reqDone = strb.reqFinish;
  assign reqLen  = wrIdx + IDX_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN || strb.rdClear) rdIdx <= '0;
    else if (strb.rdAdvance)   rdIdx <= rdIdx + IDX_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      msgAvail <= 1'b0;
      rdLen    <= '0;
    end else if (strb.rdTake) begin
      msgAvail <= 1'b0;
    end else if (rspAvail && !msgAvail) begin
      msgAvail <= 1'b1;
      rdLen    <= rspLen;
    end
  end

  assign rdPast   = (rdIdx >= rdLen);
  assign rdLast   = ((rdIdx + IDX_W'(1)) == rdLen);
  assign rspAddr  = rdIdx;
  assign rspTaken = strb.rdTake;

  assign flagsVal = {rxReady, txReady, 3'b000, msgAvail, 1'b0, busy};

  always_comb begin
    busRdata = 8'h00;
    if (busRd) begin
      case (busAddr)
        OFS_DATA:   busRdata = dataReg;
        OFS_STATUS: busRdata = statusReg;
        OFS_FLAGS:  busRdata = flagsVal;
        default:    busRdata = 8'h00;
      endcase
    end
  end

  // R2
  flagsNotOnes_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr == OFS_FLAGS) |-> (busRdata != 8'hFF));

  // R4
  statusHigh_chk: assert property (@(posedge clk) disable iff (!rstN)
    statusReg[7]);

  // R3
  dataHeldBusy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !strb.exec) |=> $stable(dataReg));

  // R6
  reqInRange_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqWe |-> (reqAddr < IDX_W'(DEPTH)));

  // R10
  msgDropOnTake_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(msgAvail) |-> $past(strb.rdTake));

endmodule

// File: rtl/msgPortTarget.sv
module msgPortTarget
  import msgTgtPkg::*;
#(
  parameter  int DEPTH       = 80,
  parameter  int BUSY_CYCLES = 2,
  localparam int IDX_W       = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       busAddr,
  input  logic             busRd,
  input  logic             busWr,
  input  logic [7:0]       busWdata,
  output logic [7:0]       busRdata,
  output logic             reqWe,
  output logic [IDX_W-1:0] reqAddr,
  output logic [7:0]       reqData,
  output logic             reqDone,
  output logic [IDX_W-1:0] reqLen,
  input  logic             rspAvail,
  input  logic [IDX_W-1:0] rspLen,
  output logic [IDX_W-1:0] rspAddr,
  input  logic [7:0]       rspData,
  output logic             rspTaken
);

  strobeT strb;
  logic   busy, txReady, rxReady, dataWrEn;
  logic   msgAvail, wrFull, wrOvf, rdPast, rdLast;

  msgTgtCtrl #(.BUSY_CYCLES(BUSY_CYCLES)) ctrl_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busWdata(busWdata),
    .msgAvail(msgAvail), .wrFull(wrFull), .wrOvf(wrOvf), .rdPast(rdPast), .rdLast(rdLast),
    .strb(strb), .busy(busy), .txReady(txReady), .rxReady(rxReady), .dataWrEn(dataWrEn)
  );

  msgTgtDatapath #(.DEPTH(DEPTH), .IDX_W(IDX_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .dataWrEn(dataWrEn), .busWdata(busWdata),
    .busAddr(busAddr), .busRd(busRd), .busy(busy), .txReady(txReady), .rxReady(rxReady),
    .rspAvail(rspAvail), .rspLen(rspLen), .rspData(rspData), .busRdata(busRdata),
    .msgAvail(msgAvail), .wrFull(wrFull), .wrOvf(wrOvf), .rdPast(rdPast), .rdLast(rdLast),
    .reqWe(reqWe), .reqAddr(reqAddr), .reqData(reqData), .reqDone(reqDone), .reqLen(reqLen),
    .rspAddr(rspAddr), .rspTaken(rspTaken)
  );

endmodule

// File: tb/msgPortTarget_tb_top.sv
module msgPortTarget_tb_top;

  localparam int DEPTH = 80;
  localparam int BUSY  = 2;
  localparam int IDX_W = $clog2(DEPTH + 1);

  logic             clk = 1'b0;
  logic             rstN;
  logic [1:0]       busAddr;
  logic             busRd, busWr;
  logic [7:0]       busWdata, busRdata;
  logic             reqWe, reqDone, rspAvail, rspTaken;
  logic [IDX_W-1:0] reqAddr, reqLen, rspLen, rspAddr;
  logic [7:0]       reqData, rspData;
  logic [7:0]       rspMem [DEPTH];

  int nChecks = 0;
  int nErrors = 0;

  always #4 clk = ~clk;

  assign rspData = (rspAddr < IDX_W'(DEPTH)) ? rspMem[rspAddr] : 8'h00;

  msgPortTarget #(.DEPTH(DEPTH), .BUSY_CYCLES(BUSY)) dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
    .busWdata(busWdata), .busRdata(busRdata), .reqWe(reqWe), .reqAddr(reqAddr),
    .reqData(reqData), .reqDone(reqDone), .reqLen(reqLen), .rspAvail(rspAvail),
    .rspLen(rspLen), .rspAddr(rspAddr), .rspData(rspData), .rspTaken(rspTaken)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int         mPhase, mCnt, mWr, mRd, mLen;
  bit         mBusy, mOvf, mMsg;
  logic [7:0] mStatus, mData, mCode;
  bit         execNow;
  logic [7:0] eStatus, eData;
  int         ePhase;
  bit         ePush, eFin, eTake, eAdv, eClrW, eClrR;
  logic [7:0] capQ [$];
  int         doneCnt = 0, lastLen = 0, takeCnt = 0;

  function automatic logic [7:0] expReg(input logic [1:0] a);
    bit rx, tx;
    rx = !mBusy && (mPhase == 2 || (mPhase == 0 && mMsg));
    tx = !mBusy && (mPhase != 2);
    case (a)
      2'd0: return mData;
      2'd1: return mStatus;
      2'd2: return {rx, tx, 3'b000, mMsg, 1'b0, mBusy};
      default: return 8'h00;
    endcase
  endfunction

  always @(negedge clk) begin
    #2;
    execNow = 0; ePush = 0; eFin = 0; eTake = 0; eAdv = 0; eClrW = 0; eClrR = 0;
    eStatus = mStatus; eData = mData; ePhase = mPhase;
    if (rstN) begin
      execNow = mBusy && (mCnt == 0);
      if (execNow) begin
        eStatus = 8'hC0; eData = 8'h02; ePhase = 0;
        if (mPhase == 0) begin
          if (mCode == 8'h40) eData = 8'h00;
          else if (mCode == 8'h41) begin eStatus = 8'hC1; eData = mData; ePhase = 1; ePush = 1; end
          else if (mCode == 8'h44) begin
            if (mMsg) begin eStatus = 8'hC4; ePhase = 2; eAdv = 1; eData = rspMem[mRd]; end
            else eData = 8'h03;
          end
        end else if (mPhase == 1) begin
          if (mCode == 8'h42) begin eStatus = 8'hC2; eData = mData; ePhase = 1; ePush = 1; end
          else if (mCode == 8'h43) begin
            eStatus = 8'hC3; ePush = 1; eClrW = 1;
            if (mOvf || mWr >= DEPTH) eData = 8'h05;
            else begin eData = 8'h00; eFin = 1; end
          end else begin
            eClrW = 1;
            if (mCode == 8'h40) eData = 8'h01;
          end
        end else begin
          if (mCode == 8'h45 && mRd < mLen) begin
            eStatus = (mRd == mLen - 1) ? 8'hC6 : 8'hC5;
            eData = rspMem[mRd]; ePhase = 2; eAdv = 1;
          end else if (mCode == 8'h46) begin
            eData = 8'h00; eTake = 1; eClrR = 1;
          end else begin
            eClrR = 1;
            if (mCode == 8'h40) eData = 8'h01;
          end
        end
      end
      // per-cycle port comparison
      check(reqWe === (ePush && mWr < DEPTH), "R5 reqWe", int'(reqWe), int'(ePush && mWr < DEPTH));
      if (reqWe) begin
        check(reqAddr == IDX_W'(mWr), "R5 reqAddr", int'(reqAddr), mWr);
        check(reqData == mData, "R5 reqData", int'(reqData), int'(mData));
        capQ.push_back(reqData);
      end
      check(reqDone === eFin, "R5 reqDone", int'(reqDone), int'(eFin));
      if (reqDone) begin
        check(int'(reqLen) == mWr + 1, "R5 reqLen", int'(reqLen), mWr + 1);
        doneCnt++; lastLen = int'(reqLen);
      end
      check(rspTaken === eTake, "R9 rspTaken", int'(rspTaken), int'(eTake));
      if (rspTaken) begin takeCnt++; rspAvail = 1'b0; end
      check(int'(rspAddr) == mRd, "R8 rspAddr", int'(rspAddr), mRd);
      if (busRd) check(busRdata === expReg(busAddr), "R2 readback", int'(busRdata), int'(expReg(busAddr)));
    end
  end

  always @(posedge clk) begin
    if (!rstN) begin
      mPhase = 0; mCnt = 0; mWr = 0; mRd = 0; mLen = 0;
      mBusy = 0; mOvf = 0; mMsg = 0;
      mStatus = 8'hC0; mData = 8'h00; mCode = 8'h40;
    end else begin
      if (execNow) begin
        mStatus = eStatus; mData = eData; mPhase = ePhase; mBusy = 0;
        if (ePush) begin
          if (mWr < DEPTH) mWr++;
          else mOvf = 1;
        end
        if (eClrW) begin mWr = 0; mOvf = 0; end
        if (eAdv) mRd++;
        if (eClrR) mRd = 0;
      end else if (mBusy) begin
        mCnt--;
      end else if (busWr) begin
        if (busAddr == 2'd0) mData = busWdata;
        else if (busAddr == 2'd1) mCode = busWdata;
        else if (busAddr == 2'd2 && busWdata[0]) begin mBusy = 1; mCnt = BUSY - 1; end
      end
      if (eTake) mMsg = 0;
      else if (!mMsg && rspAvail) begin mMsg = 1; mLen = int'(rspLen); end
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(input logic [1:0] a, input logic [7:0] v);
    @(negedge clk); busAddr = a; busWdata = v; busWr = 1'b1;
    @(negedge clk); busWr = 1'b0;
  endtask

  task automatic rdReg(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk); busAddr = a; busRd = 1'b1; #1 v = busRdata;
    @(negedge clk); busRd = 1'b0;
  endtask

  task automatic checkReg(input logic [1:0] a, input logic [7:0] exp, input string tag);
    logic [7:0] v;
    rdReg(a, v);
    check(v === exp, tag, int'(v), int'(exp));
  endtask

  task automatic op(input logic [7:0] code, input logic [7:0] d);
    wr(2'd0, d); wr(2'd1, code); wr(2'd2, 8'h01);
    repeat (BUSY + 1) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nErrors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

  initial begin
    rstN = 1'b0; busAddr = '0; busRd = 0; busWr = 0; busWdata = '0;
    rspAvail = 0; rspLen = '0;
    for (int i = 0; i < DEPTH; i++) rspMem[i] = 8'h00;
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1 reset values
    checkReg(2'd1, 8'hC0, "R1 status");
    checkReg(2'd0, 8'h00, "R1 data");
    checkReg(2'd2, 8'h40, "R1 flags");
    checkReg(2'd3, 8'h00, "R2 unused offset");

    // R3 busy window, R4 get-status
    wr(2'd0, 8'h55); wr(2'd1, 8'h40); wr(2'd2, 8'h01);
    checkReg(2'd2, 8'h01, "R3 busy/R7 tx low");
    repeat (2) @(negedge clk);
    checkReg(2'd1, 8'hC0, "R4 ready status");
    checkReg(2'd0, 8'h00, "R4 get-status data");

    // R3 flags write without bit 0
    wr(2'd1, 8'h41); wr(2'd2, 8'h00);
    repeat (3) @(negedge clk);
    checkReg(2'd2, 8'h40, "R3 no start flags");
    checkReg(2'd1, 8'hC0, "R3 no start status");

    // R5 three-byte request, R3 writes during busy
    capQ.delete();
    op(8'h41, 8'hA1);
    checkReg(2'd1, 8'hC1, "R4 write-start status");
    checkReg(2'd0, 8'hA1, "R5 data kept");
    wr(2'd0, 8'hB2); wr(2'd1, 8'h42); wr(2'd2, 8'h01);
    wr(2'd0, 8'h99);
    wr(2'd1, 8'h47);
    checkReg(2'd0, 8'hB2, "R3 data write while busy");
    checkReg(2'd1, 8'hC2, "R3 code write while busy");
    op(8'h43, 8'hC3);
    checkReg(2'd1, 8'hC3, "R5 write-end status");
    checkReg(2'd0, 8'h00, "R5 write-end code");
    check(capQ.size() == 3, "R5 byte count", capQ.size(), 3);
    if (capQ.size() == 3) begin
      check(capQ[0] == 8'hA1, "R5 byte0", int'(capQ[0]), 8'hA1);
      check(capQ[1] == 8'hB2, "R5 byte1", int'(capQ[1]), 8'hB2);
      check(capQ[2] == 8'hC3, "R5 byte2", int'(capQ[2]), 8'hC3);
    end
    check(doneCnt == 1 && lastLen == 3, "R5 done len", lastLen, 3);
    checkReg(2'd2, 8'h40, "R7 ready flags");

    // R8/R9/R10 four-byte response
    for (int i = 0; i < 4; i++) rspMem[i] = 8'h3A + 8'(i);
    rspLen = IDX_W'(4); rspAvail = 1'b1;
    repeat (2) @(negedge clk);
    checkReg(2'd2, 8'hC4, "R10 msg flags/R7 rx");
    op(8'h44, 8'h00);
    checkReg(2'd1, 8'hC4, "R8 read-start status");
    checkReg(2'd0, 8'h3A, "R8 byte0");
    checkReg(2'd2, 8'h84, "R7 read-phase flags");
    op(8'h45, 8'h00);
    checkReg(2'd1, 8'hC5, "R8 next status");
    checkReg(2'd0, 8'h3B, "R8 byte1");
    op(8'h45, 8'h00);
    checkReg(2'd0, 8'h3C, "R8 byte2");
    op(8'h45, 8'h00);
    checkReg(2'd1, 8'hC6, "R8 last status");
    checkReg(2'd0, 8'h3D, "R8 byte3");
    op(8'h46, 8'h00);
    checkReg(2'd1, 8'hC0, "R9 read-end status");
    checkReg(2'd0, 8'h00, "R9 read-end code");
    check(takeCnt == 1, "R9 taken pulse", takeCnt, 1);
    checkReg(2'd2, 8'h40, "R10 msg cleared");

    // R11 illegal codes
    op(8'h47, 8'h00);
    checkReg(2'd1, 8'hC0, "R11 status");
    checkReg(2'd0, 8'h02, "R11 idle illegal");
    op(8'h41, 8'h11);
    op(8'h45, 8'h00);
    checkReg(2'd0, 8'h02, "R11 write-phase illegal");
    op(8'h42, 8'h12);
    checkReg(2'd0, 8'h02, "R11 back to ready");
    check(doneCnt == 1, "R11 no completion", doneCnt, 1);

    // R12 abort and no-response
    op(8'h41, 8'h21);
    op(8'h40, 8'h00);
    checkReg(2'd0, 8'h01, "R12 abort");
    op(8'h44, 8'h00);
    checkReg(2'd0, 8'h03, "R12 no response");

    // R12 read past end, R10 availability kept
    rspMem[0] = 8'h5A; rspMem[1] = 8'h5B;
    rspLen = IDX_W'(2); rspAvail = 1'b1;
    repeat (2) @(negedge clk);
    op(8'h44, 8'h00);
    op(8'h45, 8'h00);
    checkReg(2'd1, 8'hC6, "R8 two-byte last");
    op(8'h45, 8'h00);
    checkReg(2'd1, 8'hC0, "R12 past end status");
    checkReg(2'd0, 8'h02, "R12 past end code");
    checkReg(2'd2, 8'hC4, "R10 msg held");
    op(8'h44, 8'h00);
    op(8'h46, 8'h00);
    check(takeCnt == 2, "R9 second take", takeCnt, 2);

    // R6 overflow and clean recovery
    capQ.delete();
    op(8'h41, 8'h00);
    for (int i = 1; i <= DEPTH; i++) op(8'h42, 8'(i));
    op(8'h43, 8'hEE);
    checkReg(2'd1, 8'hC3, "R6 status");
    checkReg(2'd0, 8'h05, "R6 buffer full");
    check(capQ.size() == DEPTH, "R6 stored count", capQ.size(), DEPTH);
    check(doneCnt == 1, "R6 no completion", doneCnt, 1);
    op(8'h41, 8'h61);
    op(8'h43, 8'h62);
    checkReg(2'd0, 8'h00, "R6 next message clean");
    check(doneCnt == 2 && lastLen == 2, "R6 next length", lastLen, 2);

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

endmodule